// File: doc/BRIEF.md
# Multicast Port-Membership Flush Engine

This block walks a forwarding table of 72-bit entries and drops a chosen set of egress ports from every multicast address entry it finds. A walk can cover all VLANs, or only those entries whose VLAN field matches a requested VLAN ID. An entry that still has ports left after the removal is written back with the smaller mask. An entry whose mask ends up empty is released by setting its type field to free.

A controller pulses `start` with a port mask, a VLAN ID and a wildcard flag. The engine then owns the table's synchronous memory port. Reads have one cycle of latency. The engine visits every index in turn and raises `done` for a single cycle once the last index has been handled. Supervisory entries and the broadcast address are never changed. An entry that needs no change is not rewritten.

Top module: `mcast_flush_engine`

## Requirements
- R1: Only entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN plus address) can be changed; types 0 and 2 stay untouched.
- R2: With the wildcard flag low, an entry whose VLAN field (bits 59:48) differs from the requested VLAN ID is left as it is. With the wildcard flag high, the VLAN field is ignored.
- R3: An entry is changed only if its multicast flag (bit 40) is 1.
- R4: An entry with the supervisory bit (bit 65) set is never changed.
- R5: An entry whose 48-bit address (bits 47:0) is all ones is never changed.
- R6: If the entry's port mask (bits 66 and up, one bit per port) has no bit in common with the requested mask, the entry is not changed.
- R7: Otherwise the requested bits are cleared from the entry's port mask. If some bits remain, the entry is written back with only the mask changed.
- R8: If no mask bits remain, the entry is written back with its type field set to 0 (free). All other bits are kept.
- R9: Indices are read in ascending order from 0 to DEPTH-1, with exactly one read per index. A write goes to the index read in the previous cycle, and only when the entry changes.
- R10: A `start` pulse that arrives while a walk is in progress is ignored. The walk keeps the request it accepted.
- R11: After reset the engine is idle with no memory access and `done` low. `done` is a one-cycle pulse seen 2*DEPTH+1 cycles after the accepting `start` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a walk (accepted only when idle) |
| req_mask | input | PORTS | Ports to remove |
| req_vid | input | 12 | VLAN ID to restrict the walk to |
| req_any_vlan | input | 1 | 1: ignore the VLAN field |
| done | output | 1 | One-cycle completion pulse |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_addr | output | $clog2(DEPTH) | Table index for the read or the write |
| tbl_wr_data | output | 72 | Entry to write |
| tbl_rd_data | input | 72 | Entry read, valid the cycle after `tbl_rd_en` |

## Verification
The assertions take for granted that the table port returns data exactly one cycle after a read strobe and holds it until the next read. They also take for granted that nothing else writes the table while a walk runs. This is why the write-side checks can compare `tbl_wr_data` against `tbl_rd_data` in the same cycle.

The bench models exactly such a memory and loads it only while the engine is idle. It sweeps every removal mask against generated tables that mix all four entry types, both VLAN values, the supervisory and broadcast cases, and walks that are wildcard, matching or non-matching. Some walks also get a second `start` pulse injected partway through.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int ENTRY_W   = 72;
    localparam int MASK_LSB  = 66;
    localparam int MAX_PORTS = ENTRY_W - MASK_LSB;
    localparam int KIND_LSB  = 60;
    localparam int VID_LSB   = 48;
    localparam int VID_W     = 12;
    localparam int MC_BIT    = 40;
    localparam int SUP_BIT   = 65;
    localparam int MAC_W     = 48;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VADDR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        kind_e                 kind;
        logic [VID_W-1:0]      vid;
        logic                  mcast;
        logic                  sup;
        logic                  bcast;
        logic [MAX_PORTS-1:0]  members;
    } entry_view_t;

    function automatic entry_view_t view_entry(entry_t e);
        entry_view_t v;
        v.kind    = kind_e'(e[KIND_LSB +: 2]);
        v.vid     = e[VID_LSB +: VID_W];
        v.mcast   = e[MC_BIT];
        v.sup     = e[SUP_BIT];
        v.bcast   = &e[MAC_W-1:0];
        v.members = e[MASK_LSB +: MAX_PORTS];
        return v;
    endfunction

endpackage

// File: rtl/mcf_decide.sv
module mcf_decide
    import mcf_pkg::*;
#(
    parameter int PORTS = 3
) (
    input  entry_t                   entry_i,
    input  logic [PORTS-1:0]         mask_i,
    input  logic [VID_W-1:0]         vid_i,
    input  logic                     any_vlan_i,
    output logic                     modify_o,
    output entry_t                   entry_o
);
    entry_view_t      v;
    logic             kind_ok;
    logic             vlan_ok;
    logic [PORTS-1:0] cur;
    logic [PORTS-1:0] remain;

    always_comb begin
        v        = view_entry(entry_i);
        kind_ok  = (v.kind == KIND_ADDR) || (v.kind == KIND_VADDR);
        vlan_ok  = any_vlan_i || (v.vid == vid_i);
        cur      = v.members[PORTS-1:0];
        remain   = cur & ~mask_i;
        modify_o = kind_ok && vlan_ok && v.mcast && !v.sup && !v.bcast
                   && ((cur & mask_i) != '0);
        entry_o  = entry_i;
        if (remain == '0) begin
            entry_o[KIND_LSB +: 2] = KIND_FREE;
        end else begin
            entry_o[MASK_LSB +: PORTS] = remain;
        end
    end
endmodule

// File: rtl/mcf_walker.sv
module mcf_walker
    import mcf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          accept_o,
    output logic          rd_en_o,
    output logic          eval_o,
    output logic          done_o,
    output logic [AW-1:0] idx_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    walk_st_e      st;
    logic [AW-1:0] idx;

    assign accept_o = (st == ST_IDLE) && start_i;
    assign rd_en_o  = (st == ST_READ);
    assign eval_o   = (st == ST_EVAL);
    assign done_o   = (st == ST_DONE);
    assign idx_o    = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st  <= ST_READ;
                        idx <= '0;
                    end
                end
                ST_READ: st <= ST_EVAL;
                ST_EVAL: begin
                    if (idx == LAST) begin
                        st <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= ST_READ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mcast_flush_engine.sv
module mcast_flush_engine
    import mcf_pkg::*;
#(
    parameter int PORTS = 3,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PORTS-1:0]     req_mask,
    input  logic [VID_W-1:0]     req_vid,
    input  logic                 req_any_vlan,
    output logic                 done,
    output logic                 tbl_rd_en,
    output logic                 tbl_wr_en,
    output logic [AW-1:0]        tbl_addr,
    output logic [ENTRY_W-1:0]   tbl_wr_data,
    input  logic [ENTRY_W-1:0]   tbl_rd_data
);
    logic             accept;
    logic             eval;
    logic             modify;
    logic [PORTS-1:0] held_mask;
    logic [VID_W-1:0] held_vid;
    logic             held_any;
    entry_t           next_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mask <= '0;
            held_vid  <= '0;
            held_any  <= 1'b0;
        end else if (accept) begin
            held_mask <= req_mask;
            held_vid  <= req_vid;
            held_any  <= req_any_vlan;
        end
    end

    mcf_walker #(.DEPTH(DEPTH)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .accept_o (accept),
        .rd_en_o  (tbl_rd_en),
        .eval_o   (eval),
        .done_o   (done),
        .idx_o    (tbl_addr)
    );

    mcf_decide #(.PORTS(PORTS)) u_dec (
        .entry_i    (tbl_rd_data),
        .mask_i     (held_mask),
        .vid_i      (held_vid),
        .any_vlan_i (held_any),
        .modify_o   (modify),
        .entry_o    (next_entry)
    );

    assign tbl_wr_en   = eval && modify;
    assign tbl_wr_data = next_entry;
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker
    import mcf_pkg::*;
#(
    parameter int PORTS = 3,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               tbl_rd_en,
    input logic               tbl_wr_en,
    input logic [AW-1:0]      tbl_addr,
    input logic [ENTRY_W-1:0] tbl_wr_data,
    input logic [ENTRY_W-1:0] tbl_rd_data
);
    logic [AW-1:0] prev_rd;
    logic          walking;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd <= '0;
            walking <= 1'b0;
        end else if (done) begin
            walking <= 1'b0;
        end else if (tbl_rd_en) begin
            prev_rd <= tbl_addr;
            walking <= 1'b1;
        end
    end

    assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> ($past(tbl_rd_en) && tbl_addr == $past(tbl_addr)));

    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(tbl_rd_en && tbl_wr_en));

    assert_first_index_R9: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_en && !walking) |-> tbl_addr == '0);

    assert_ascending_R9: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_en && walking) |-> tbl_addr == prev_rd + 1'b1);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tbl_rd_en && !tbl_wr_en));

    assert_kind_R1: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> tbl_rd_data[KIND_LSB]);

    assert_mcast_R3: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> tbl_rd_data[MC_BIT]);

    assert_sup_R4: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> !tbl_rd_data[SUP_BIT]);

    assert_bcast_R5: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> !(&tbl_rd_data[MAC_W-1:0]));

    assert_mask_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> ((tbl_wr_data[MASK_LSB +: PORTS]
                        & ~tbl_rd_data[MASK_LSB +: PORTS]) == '0));

    assert_low_bits_kept_R8: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> tbl_wr_data[KIND_LSB-1:0] == tbl_rd_data[KIND_LSB-1:0]);
endmodule

bind mcast_flush_engine mcf_checker #(.PORTS(PORTS), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_addr    (tbl_addr),
    .tbl_wr_data (tbl_wr_data),
    .tbl_rd_data (tbl_rd_data)
);

// File: tb/tb_mcast_flush_engine.sv
module tb_mcast_flush_engine;
    localparam int P  = 3;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [P-1:0]  req_mask = '0;
    logic [11:0]   req_vid = '0;
    logic          req_any_vlan = 1'b0;
    logic          done;
    logic          tbl_rd_en;
    logic          tbl_wr_en;
    logic [AW-1:0] tbl_addr;
    logic [71:0]   tbl_wr_data;
    logic [71:0]   tbl_rd_data;

    logic [71:0] mem [D];
    logic [71:0] exp_tbl [D];
    int wr_total = 0;
    int done_total = 0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mcast_flush_engine #(.PORTS(P), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .start(start), .req_mask(req_mask),
        .req_vid(req_vid), .req_any_vlan(req_any_vlan), .done(done),
        .tbl_rd_en(tbl_rd_en), .tbl_wr_en(tbl_wr_en), .tbl_addr(tbl_addr),
        .tbl_wr_data(tbl_wr_data), .tbl_rd_data(tbl_rd_data)
    );

    always @(posedge clk) begin
        if (tbl_rd_en) tbl_rd_data <= mem[tbl_addr];
        if (tbl_wr_en) mem[tbl_addr] <= tbl_wr_data;
        if (tbl_wr_en) wr_total <= wr_total + 1;
        if (done) done_total <= done_total + 1;
        cycles <= cycles + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [71:0] gen(input int i, input int seed);
        logic [71:0] e = '0;
        e[71:69] = 3'(seed);
        e[68:66] = 3'((i * 3 + seed) % 8);
        e[65]    = ((i * 7 + seed) % 6 == 0);
        e[64]    = i[0];
        e[63:62] = 2'(i);
        e[61:60] = 2'((i + seed) % 4);
        e[59:48] = ((i + seed) % 3 == 0) ? 12'd5 : 12'd6;
        if ((i + seed * 3) % 9 == 0) begin
            e[47:0] = '1;
        end else begin
            e[47:0] = {8'(i * 2), 8'(seed), 32'h5A00_0000 | 32'(i)};
            e[40]   = ((i * 5 + seed) % 4 != 0);
        end
        return e;
    endfunction

    function automatic logic [71:0] model(input logic [71:0] e, input logic [P-1:0] m,
                                          input logic [11:0] vid, input bit any,
                                          output string why, output bit wr);
        logic [71:0] r = e;
        logic [P-1:0] left;
        wr = 0;
        if (!(e[61:60] == 2'd1 || e[61:60] == 2'd3)) why = "R1";
        else if (!any && e[59:48] != vid)            why = "R2";
        else if (!e[40])                             why = "R3";
        else if (e[65])                              why = "R4";
        else if (e[47:0] == 48'hFFFF_FFFF_FFFF)      why = "R5";
        else if ((e[68:66] & m) == 0)                why = "R6";
        else begin
            wr = 1;
            left = e[68:66] & ~m;
            if (left == 0) begin why = "R8"; r[61:60] = 2'd0; end
            else begin why = "R7"; r[68:66] = left; end
        end
        return r;
    endfunction

    task automatic run(input logic [P-1:0] m, input logic [11:0] vid, input bit any,
                       input int seed, input bit inject);
        int w0, d0, exp_wr, lat;
        bit seen;
        string why;
        bit wr;
        exp_wr = 0;
        for (int i = 0; i < D; i++) begin
            mem[i] = gen(i, seed);
            exp_tbl[i] = model(mem[i], m, vid, any, why, wr);
            exp_wr += int'(wr);
        end
        w0 = wr_total;
        d0 = done_total;
        start = 1'b1; req_mask = m; req_vid = vid; req_any_vlan = any;
        lat = 0;
        seen = 0;
        for (int k = 1; k <= 4 * D + 8; k++) begin
            @(negedge clk);
            start = inject && (k == 5);
            if (inject && k == 5) begin
                req_mask = ~m; req_any_vlan = 1'b1;
            end
            if (done) begin lat = k; seen = 1; break; end
        end
        start = 1'b0;
        @(negedge clk);
        // R11: done latency and single pulse
        check(seen && lat == 2 * D + 1, "R11", "done latency", 72'(lat), 72'(2 * D + 1));
        check(done_total - d0 == 1, "R11", "done pulse count", 72'(done_total - d0), 72'd1);
        // R9: only modified entries are written
        check(wr_total - w0 == exp_wr, "R9", "write count", 72'(wr_total - w0), 72'(exp_wr));
        for (int i = 0; i < D; i++) begin
            void'(model(gen(i, seed), m, vid, any, why, wr));
            check(mem[i] == exp_tbl[i], inject ? "R10" : why, "entry",
                  mem[i], exp_tbl[i]);
        end
    endtask

    initial begin
        @(posedge clk);
        while (cycles < 150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle after reset, no access
        check(!tbl_rd_en && !tbl_wr_en && !done, "R11", "reset idle",
              {69'd0, tbl_rd_en, tbl_wr_en, done}, 72'd0);
        repeat (4) @(negedge clk);
        check(!tbl_rd_en && !tbl_wr_en, "R11", "stays idle without start",
              {70'd0, tbl_rd_en, tbl_wr_en}, 72'd0);
        for (int seed = 0; seed < 6; seed++)
            for (int mode = 0; mode < 4; mode++)
                for (int mk = 0; mk < (1 << P); mk++)
                    run(P'(mk), (mode == 3) ? 12'd7 : (mode == 2 ? 12'd6 : 12'd5),
                        mode == 0, seed, 1'b0);
        // R10: second start during a walk is ignored
        for (int seed = 0; seed < 4; seed++)
            run(P'(seed + 1), 12'd5, 1'b0, seed, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule